// File: doc/BRIEF.md
# In-Order Commit Result Checker

This block sits behind the retirement stage of an out-of-order core and re-validates every instruction that core retires. Each retired instruction arrives as one packet, in program order, carrying a 3-bit operation code, two source register numbers, a destination register number, the two operand values the core used, the result the core produced, and a flag that marks the second operand as an immediate. The checker holds its own copy of the architectural register file. It performs two checks on each packet. The storage check compares the reported operands with its own registers. The compute check recomputes the result on a private ALU and compares it with the reported result. Only a packet that passes both checks updates the checker's register file.

When a check fails, the checker's own state is taken as correct. It raises an error with a cause code and the sequence number of the offending packet, and it stops accepting packets until the core acknowledges a restart from that instruction. A watchdog also raises an error when the core retires nothing for a programmable number of enabled cycles, which catches a core stuck on a corrupted dependence.

The packet input is a valid/ready stream. `in_ready` is high whenever no error is pending, so one packet is taken on every clock edge where `in_valid` and `in_ready` are both high. While an error is pending, `in_ready` is low and the producer must hold or drop its packet. There is no other back-pressure.

Top module: `commit_checker`

## Requirements
- R1: Synchronous reset clears all registers of the checker's file to zero and the sequence and watchdog counters. After reset `err_valid` is 0, `err_cause` is 00, `err_seq` is 0 and `in_ready` is 1.
- R2: Storage check: an accepted packet fails when the file's value at `in_rs1` differs from `in_a`, or when `in_imm` is 0 and the file's value at `in_rs2` differs from `in_b`. When `in_imm` is 1, `in_rs2` is not compared. The failure sets `err_valid` with `err_cause` = 01 on the next edge.
- R3: Compute check: the opcodes are 000 add, 001 subtract (a-b), 010 and, 011 or, 100 xor and 101 shift-left of a by b[4:0]. The operation is applied to `in_a` and `in_b`. A result different from `in_res` raises `err_cause` = 10. The opcodes 110 and 111 always fail with cause 10.
- R4: When both checks fail on one packet, the cause reported is 01.
- R5: The destination register is written with `in_res` only when both checks pass. A failing packet leaves the file unchanged.
- R6: Packets may arrive on consecutive cycles. A register written by one packet is seen by the storage check of the very next packet.
- R7: Accepted packets are numbered from 1 since reset. A check error reports the number of the failing packet in `err_seq`. A timeout reports the number of packets accepted so far.
- R8: While `err_valid` is 1, `in_ready` is 0 and `err_cause` and `err_seq` hold. Offered packets are ignored and do not advance the count. A `restart_ack` pulse clears the error on the next edge and restarts the watchdog.
- R9: The watchdog counts the cycles in which `wd_en` is 1 and no packet is accepted. The count is held while `wd_en` is 0 and cleared by every accepted packet. It raises `err_cause` = 11 at the edge that ends the TIMEOUT-th such cycle.
- R10: Register 0 is an ordinary register that can be written and read like any other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Retired-instruction packet is offered |
| in_ready | output | 1 | Checker accepts a packet this cycle |
| in_op | input | 3 | Operation code |
| in_imm | input | 1 | Second operand is an immediate (skip check of rs2) |
| in_rs1 | input | 4 | First source register number |
| in_rs2 | input | 4 | Second source register number |
| in_rd | input | 4 | Destination register number |
| in_a | input | 32 | First operand value used by the core |
| in_b | input | 32 | Second operand value used by the core |
| in_res | input | 32 | Result produced by the core |
| wd_en | input | 1 | Enables the retirement watchdog |
| restart_ack | input | 1 | Core acknowledges restart, clears the error |
| err_valid | output | 1 | Error pending |
| err_cause | output | 2 | 01 storage, 10 compute, 11 timeout |
| err_seq | output | 16 | Sequence number tied to the error |

## Verification
The bench builds register state through immediate-form packets. It then sends packets whose operands either match that state or carry one corrupted value, so a storage failure can be told apart from a compute failure. A packet that corrupts both values shows which cause has priority. Every opcode is run with operands chosen so that a wrong operation gives a different result, and the reserved opcodes are included. A back-to-back read after a write exercises the same-cycle forwarding path. The watchdog is run with its enable held low and then high, and the error is checked one cycle before the limit and at the limit.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100,
    OP_SHL = 3'b101
  } cc_op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_STORE = 2'b01,
    CAUSE_COMP  = 2'b10,
    CAUSE_TIME  = 2'b11
  } cc_cause_e;
endpackage

// File: rtl/cc_regfile.sv
module cc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] mem [NREG];

  // Flop array read combinationally: a write at edge N is visible at N+1,
  // which is the forwarding the back-to-back case needs (R6).
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)
        mem[i] <= '0;
      else if (we && wa == AW'(i))
        mem[i] <= wd;
    end
  end

  assign rd1 = mem[ra1];
  assign rd2 = mem[ra2];

  // R5: a write lands at the addressed entry
  a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(wa)] == $past(wd));
endmodule

// File: rtl/cc_alu.sv
module cc_alu
  import cc_pkg::*;
#(
  parameter int W   = 32,
  localparam int SH = $clog2(W)
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         bad_op
);
  always_comb begin
    bad_op = 1'b0;
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = a << b[SH-1:0];
      default: begin
        y      = '0;
        bad_op = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/cc_watchdog.sv
module cc_watchdog #(
  parameter int TIMEOUT = 1024,
  localparam int CW     = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic kick,
  output logic fire
);
  logic [CW-1:0] cnt;

  assign fire = en && !kick && (cnt == CW'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (rst || kick || fire)
      cnt <= '0;
    else if (en)
      cnt <= cnt + 1'b1;
  end

  // R9: the idle count never reaches the limit itself
  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(TIMEOUT));

  // R9: count frozen while disabled and not kicked
  a_r9_hold_disabled: assert property (@(posedge clk) disable iff (rst)
    (!en && !kick) |=> $stable(cnt));
endmodule

// File: rtl/commit_checker.sv
module commit_checker
  import cc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NREG    = 16,
  parameter int SEQW    = 16,
  parameter int TIMEOUT = 1024,
  localparam int AW     = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic            in_imm,
  input  logic [AW-1:0]   in_rs1,
  input  logic [AW-1:0]   in_rs2,
  input  logic [AW-1:0]   in_rd,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic [XLEN-1:0] in_res,
  input  logic            wd_en,
  input  logic            restart_ack,
  output logic            err_valid,
  output logic [1:0]      err_cause,
  output logic [SEQW-1:0] err_seq
);
  logic [XLEN-1:0] arch_a, arch_b, alu_y;
  logic            alu_bad, store_ok, comp_ok, accept, rf_we, wd_fire, wd_kick;
  logic [SEQW-1:0] seq_cnt;

  assign in_ready = !err_valid;
  assign accept   = in_valid && in_ready;
  assign store_ok = (arch_a == in_a) && (in_imm || arch_b == in_b);
  assign comp_ok  = !alu_bad && (alu_y == in_res);
  assign rf_we    = accept && store_ok && comp_ok;
  assign wd_kick  = accept || restart_ack;

  cc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (in_rs1),
    .ra2 (in_rs2),
    .rd1 (arch_a),
    .rd2 (arch_b),
    .we  (rf_we),
    .wa  (in_rd),
    .wd  (in_res)
  );

  cc_alu #(.W(XLEN)) u_alu (
    .op     (in_op),
    .a      (in_a),
    .b      (in_b),
    .y      (alu_y),
    .bad_op (alu_bad)
  );

  cc_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
    .clk  (clk),
    .rst  (rst),
    .en   (wd_en && !err_valid),
    .kick (wd_kick),
    .fire (wd_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_cnt   <= '0;
      err_valid <= 1'b0;
      err_cause <= CAUSE_NONE;
      err_seq   <= '0;
    end else begin
      if (accept)
        seq_cnt <= seq_cnt + 1'b1;
      if (accept && !store_ok) begin
        err_valid <= 1'b1;
        err_cause <= CAUSE_STORE;
        err_seq   <= seq_cnt + 1'b1;
      end else if (accept && !comp_ok) begin
        err_valid <= 1'b1;
        err_cause <= CAUSE_COMP;
        err_seq   <= seq_cnt + 1'b1;
      end else if (wd_fire) begin
        err_valid <= 1'b1;
        err_cause <= CAUSE_TIME;
        err_seq   <= seq_cnt;
      end else if (err_valid && restart_ack) begin
        err_valid <= 1'b0;
        err_cause <= CAUSE_NONE;
      end
    end
  end

  // R8: a pending error and its fields hold until acknowledged
  a_r8_error_holds: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !restart_ack) |=> (err_valid && $stable(err_cause) && $stable(err_seq)));

  // R2, R4: operand disagreement reports storage cause
  a_r2_store_cause: assert property (@(posedge clk) disable iff (rst)
    (accept && !store_ok) |=> (err_valid && err_cause == 2'b01));

  // R3: recompute disagreement reports compute cause
  a_r3_comp_cause: assert property (@(posedge clk) disable iff (rst)
    (accept && store_ok && !comp_ok) |=> (err_valid && err_cause == 2'b10));

  // R7: every accepted packet advances the count by one
  a_r7_seq_step: assert property (@(posedge clk) disable iff (rst)
    accept |=> seq_cnt == $past(seq_cnt) + 1'b1);

  // R9: watchdog expiry reports timeout cause
  a_r9_timeout_cause: assert property (@(posedge clk) disable iff (rst)
    wd_fire |=> (err_valid && err_cause == 2'b11));

  // R5: no register write while an error is pending
  a_r5_no_write_in_error: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> !rf_we);
endmodule

// File: tb/tb_commit_checker.sv
`timescale 1ns/1ps
module tb_commit_checker;
  localparam int TO = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_imm, wd_en, restart_ack;
  logic [2:0]  in_op;
  logic [3:0]  in_rs1, in_rs2, in_rd;
  logic [31:0] in_a, in_b, in_res;
  logic        err_valid;
  logic [1:0]  err_cause;
  logic [15:0] err_seq;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_seq = 0;

  always #4 clk = ~clk;

  commit_checker #(.TIMEOUT(TO)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_imm(in_imm), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_rd(in_rd), .in_a(in_a), .in_b(in_b), .in_res(in_res),
    .wd_en(wd_en), .restart_ack(restart_ack), .err_valid(err_valid),
    .err_cause(err_cause), .err_seq(err_seq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one packet at a falling edge, let one rising edge take it
  task automatic send(input logic [2:0] op, input bit imm, input logic [3:0] s1, input logic [3:0] s2,
                      input logic [3:0] d, input logic [31:0] a, input logic [31:0] b, input logic [31:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_imm = imm; in_rs1 = s1; in_rs2 = s2;
    in_rd = d; in_a = a; in_b = b; in_res = r;
    if (in_ready) exp_seq++;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_ok(input string req);
    chk(!err_valid, req, {31'd0, err_valid}, 32'd0);
  endtask

  task automatic expect_err(input string req, input logic [1:0] cause, input int seq);
    chk(err_valid, req, {31'd0, err_valid}, 32'd1);
    chk(err_cause == cause, req, {30'd0, err_cause}, {30'd0, cause});
    chk(err_seq == 16'(seq), req, {16'd0, err_seq}, seq);
    chk(!in_ready, req, {31'd0, in_ready}, 32'd0);
  endtask

  task automatic ack();
    @(negedge clk);
    restart_ack = 1'b1;
    @(negedge clk);
    restart_ack = 1'b0;
  endtask

  // load register d with value v through an immediate add on r0 (r0 must be 0)
  task automatic load(input logic [3:0] d, input logic [31:0] v);
    send(3'b000, 1'b1, 4'd0, 4'd0, d, 32'd0, v, v);
  endtask

  // prove register s holds v: add immediate 0, discard into r15
  task automatic probe(input string req, input logic [3:0] s, input logic [31:0] v);
    send(3'b000, 1'b1, s, 4'd0, 4'd15, v, 32'd0, v);
    expect_ok(req);
    if (err_valid) ack();
  endtask

  task automatic t_reset();
    chk(!err_valid, "R1 err_valid", {31'd0, err_valid}, 0);
    chk(err_cause == 2'b00, "R1 err_cause", {30'd0, err_cause}, 0);
    chk(err_seq == 16'd0, "R1 err_seq", {16'd0, err_seq}, 0);
    chk(in_ready, "R1 in_ready", {31'd0, in_ready}, 1);
    probe("R1 regs zero r7", 4'd7, 32'd0);
  endtask

  task automatic t_basic_and_bypass();
    load(4'd1, 32'd4);
    load(4'd2, 32'd8);                                 // R6: r2 read by the very next packet
    send(3'b000, 1'b0, 4'd1, 4'd2, 4'd3, 32'd4, 32'd8, 32'd12);
    expect_ok("R6 back-to-back add");
    probe("R5 r3 written", 4'd3, 32'd12);
  endtask

  task automatic t_all_ops();
    load(4'd4, 32'hF0F0_1234);
    load(4'd5, 32'h0FF0_0003);
    send(3'b001, 1'b0, 4'd4, 4'd5, 4'd6, 32'hF0F0_1234, 32'h0FF0_0003, 32'hE100_1231);
    expect_ok("R3 sub");
    send(3'b010, 1'b0, 4'd4, 4'd5, 4'd6, 32'hF0F0_1234, 32'h0FF0_0003, 32'h00F0_0000);
    expect_ok("R3 and");
    send(3'b011, 1'b0, 4'd4, 4'd5, 4'd6, 32'hF0F0_1234, 32'h0FF0_0003, 32'hFFF0_1237);
    expect_ok("R3 or");
    send(3'b100, 1'b0, 4'd4, 4'd5, 4'd6, 32'hF0F0_1234, 32'h0FF0_0003, 32'hFF00_1237);
    expect_ok("R3 xor");
    send(3'b101, 1'b0, 4'd4, 4'd5, 4'd6, 32'hF0F0_1234, 32'h0FF0_0003, 32'h8780_91A0);
    expect_ok("R3 shl");
    probe("R5 r6 last result", 4'd6, 32'h8780_91A0);
  endtask

  task automatic t_store_fail();
    send(3'b000, 1'b0, 4'd1, 4'd2, 4'd7, 32'd5, 32'd8, 32'd13);  // r1 holds 4, not 5
    expect_err("R2 storage mismatch", 2'b01, exp_seq);
    ack();
    expect_ok("R8 cleared by ack");
    probe("R5 r7 untouched", 4'd7, 32'd0);
    send(3'b000, 1'b1, 4'd1, 4'd9, 4'd8, 32'd4, 32'd77, 32'd81);  // rs2 not compared
    expect_ok("R2 immediate skips rs2");
  endtask

  task automatic t_comp_fail();
    send(3'b000, 1'b0, 4'd1, 4'd2, 4'd7, 32'd4, 32'd8, 32'd13);
    expect_err("R3 compute mismatch", 2'b10, exp_seq);
    ack();
    probe("R5 r7 untouched after compute fail", 4'd7, 32'd0);
    send(3'b110, 1'b0, 4'd1, 4'd2, 4'd7, 32'd4, 32'd8, 32'd0);
    expect_err("R3 reserved opcode", 2'b10, exp_seq);
    ack();
  endtask

  task automatic t_priority();
    send(3'b000, 1'b0, 4'd1, 4'd2, 4'd7, 32'd4, 32'd9, 32'd99);
    expect_err("R4 both fail reports storage", 2'b01, exp_seq);
    ack();
  endtask

  task automatic t_hold();
    int s;
    send(3'b000, 1'b0, 4'd2, 4'd2, 4'd9, 32'd1, 32'd8, 32'd9);
    s = exp_seq;
    // offered packets during the error must be ignored
    send(3'b000, 1'b1, 4'd0, 4'd0, 4'd10, 32'd0, 32'd55, 32'd55);
    send(3'b000, 1'b1, 4'd0, 4'd0, 4'd11, 32'd3, 32'd1, 32'd4);
    expect_err("R8 held during error", 2'b01, s);
    chk(exp_seq == s, "R8 bench seq frozen", exp_seq, s);
    ack();
    probe("R8 r10 not written", 4'd10, 32'd0);
    send(3'b000, 1'b1, 4'd0, 4'd0, 4'd10, 32'd1, 32'd0, 32'd1);
    expect_err("R7 numbering continues", 2'b01, s + 2);
    ack();
  endtask

  task automatic t_r0();
    load(4'd0, 32'd5);
    probe("R10 r0 holds 5", 4'd0, 32'd5);
    send(3'b000, 1'b1, 4'd0, 4'd0, 4'd0, 32'd5, 32'hFFFF_FFFB, 32'd0);
    expect_ok("R10 r0 back to 0");
  endtask

  task automatic t_timeout();
    @(negedge clk);
    wd_en = 1'b0;
    repeat (3 * TO) @(negedge clk);
    expect_ok("R9 disabled watchdog silent");
    wd_en = 1'b1;
    repeat (TO - 1) @(negedge clk);
    expect_ok("R9 one short of limit");
    wd_en = 1'b0;
    send(3'b000, 1'b1, 4'd0, 4'd0, 4'd15, 32'd0, 32'd0, 32'd0);  // accept clears count
    wd_en = 1'b1;
    repeat (TO - 1) @(negedge clk);
    expect_ok("R9 accept restarted count");
    @(negedge clk);
    expect_err("R9 timeout", 2'b11, exp_seq);
    wd_en = 1'b0;
    ack();
    expect_ok("R9 cleared");
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_imm = 1'b0; wd_en = 1'b0; restart_ack = 1'b0;
    in_op = '0; in_rs1 = '0; in_rs2 = '0; in_rd = '0; in_a = '0; in_b = '0; in_res = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_and_bypass();
    t_all_ops();
    t_store_fail();
    t_comp_fail();
    t_priority();
    t_hold();
    t_r0();
    t_timeout();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule